// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Controller

This block collects single-cycle event pulses from a communication controller's channels and housekeeping logic into two 8-bit status registers, and drives one interrupt request line for the host. Status bits always record their events. Two mask registers decide only which recorded bits may raise the request line.

The host reaches the block over a simple register bus. It presents a 2-bit address and holds a read strobe high for one or more cycles. It then takes the read data, which is latched on the clock edge that first samples the strobe high. A status read clears what was pending when the read began. Events that arrive while the read is open go into a shadow capture and merge into the register when the strobe falls, so they appear on the next read. The request line stays low while a status read is open and comes back on the edge that closes it if anything enabled is still pending. Hosts with level-sensitive inputs and hosts with edge-sensitive inputs can both use it.

A fatal synchronisation-loss flag in the second register survives reads. Only the synchronous soft reset, or the hardware reset, clears it.

Top module: `irq_stat_ctrl`

## Requirements
- R1: A read of a status register clears, from the next cycle, every clearable bit that was set on the edge that sampled the strobe rising. The read data is the register value just before that edge.
- R2: An event on any edge from the strobe-rise edge through the strobe-fall edge of a status read is kept. It is not in that read's data, and it is set in the register after the strobe-fall edge.
- R3: A status bit is set by its event whatever the masks hold. Outside a status read, irq is 1 exactly when some set status bit has its mask bit at 1.
- R4: irq is 0 on every cycle after the edge that samples the strobe rising on a status address, up to and including the edge that samples it falling.
- R5: After the strobe-fall edge, irq is 1 straight away if an enabled bit is pending, including one captured during the read.
- R6: Status register A (address 0): bits 0..2 are frame done for transmit on B1, B2 and D; bits 3..5 are the same for receive; bits 6 and 7 read 0. These are ev_frame[5:0].
- R7: Status register B (address 1): bit 0 is line state change, bit 1 is timer expiry, bit 2 is a drop to idle, bit 3 is a serial-link indication change, bit 4 is monitor receive ready (ev_misc[4:0]). Bits 5 and 6 always read 0.
- R8: Bit 7 of register B (ev_fatal) is sticky: a read does not clear it.
- R9: soft_rst for one cycle clears both status registers, both shadow captures and the fatal bit, and leaves the masks as they were. rst_n low also sets both masks to 0.
- R10: Mask A (address 2) and mask B (address 3) are written with wr_en and read back. A write to either mask never changes a status bit, and a write to a status address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| addr | input | 2 | Register address |
| rd_strb | input | 1 | Read strobe, may span several cycles |
| wr_en | input | 1 | Single-cycle write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, latched at strobe rise |
| ev_frame | input | 6 | Frame-done pulses for status register A |
| ev_misc | input | 5 | Event pulses for status register B bits 0..4 |
| ev_fatal | input | 1 | Synchronisation-loss pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong shadow or clear state shows up only on a read. A lost event is missing from the read after the one it overlapped, and a duplicated event shows up twice across two reads. The bench therefore always follows a read with a second read. A busy flag stuck high, or a faulty mask gate, shows on irq within one cycle of the strobe edge or of the event pulse. The bench samples irq on that cycle for every mask and event pair.

// File: rtl/irq_stat_pkg.sv
// Package: shared constants for the read-to-clear interrupt status controller.
// Assumes an 8-bit register bus with a 2-bit address.
package irq_stat_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // Register address map
    localparam logic [ADDR_W-1:0] ADR_STAT_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 2'd3;

    // Implemented bits and sticky bits for each status register
    localparam logic [REG_W-1:0] A_VALID  = 8'h3F;
    localparam logic [REG_W-1:0] A_STICKY = 8'h00;
    localparam logic [REG_W-1:0] B_VALID  = 8'h9F;
    localparam logic [REG_W-1:0] B_STICKY = 8'h80;
endpackage

// File: rtl/stat_capture.sv
// Module: one status register with a shadow capture.
// Events set status bits. While a read is open, clearable events go into the
// shadow, and the shadow merges into the status register on the strobe-fall edge.
// Sticky bits bypass the shadow and ignore the read clear.
// Assumes rd_start and rd_end are single-cycle and never arrive together.
module stat_capture #(
    parameter int               W      = 8,
    parameter logic [W-1:0]     VALID  = '1,
    parameter logic [W-1:0]     STICKY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] ev,
    input  logic         rd_start,
    input  logic         rd_end,
    output logic [W-1:0] stat_q,
    output logic         busy_q
);
    localparam logic [W-1:0] CLR_BITS = VALID & ~STICKY;

    logic [W-1:0] ev_v;
    logic [W-1:0] shadow_q;

    // Keep only the implemented bit positions of the incoming pulses
    always_comb ev_v = ev & VALID;

    // Status, shadow and busy-flag update
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            stat_q   <= '0;
            shadow_q <= '0;
            busy_q   <= 1'b0;
        end else if (rd_start) begin
            stat_q   <= (stat_q | ev_v) & STICKY;
            shadow_q <= shadow_q | (ev_v & CLR_BITS);
            busy_q   <= 1'b1;
        end else if (busy_q && rd_end) begin
            stat_q   <= stat_q | shadow_q | ev_v;
            shadow_q <= '0;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            stat_q   <= stat_q | (ev_v & STICKY);
            shadow_q <= shadow_q | (ev_v & CLR_BITS);
        end else begin
            stat_q   <= stat_q | ev_v;
        end
    end

    // R1
    r1_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !soft_rst) |=> ((stat_q & CLR_BITS) == '0));

    // R2
    r2_shadow_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_end && !soft_rst) |=> ((stat_q & $past(shadow_q)) == $past(shadow_q)));

    // R8
    r8_sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst) |=> ((stat_q & $past(stat_q) & STICKY) == ($past(stat_q) & STICKY)));
endmodule

// File: rtl/reg_port.sv
// Module: host register port.
// Finds the strobe edges, latches read data on the strobe rise, holds the two
// mask registers and raises the start pulse for the addressed status register.
// Assumes addr holds steady while rd_strb is high.
module reg_port
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_strb,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [REG_W-1:0]  stat_a,
    input  logic [REG_W-1:0]  stat_b,
    output logic [REG_W-1:0]  rd_data,
    output logic [REG_W-1:0]  mask_a,
    output logic [REG_W-1:0]  mask_b,
    output logic              start_a,
    output logic              start_b,
    output logic              rd_end
);
    logic rd_q;
    logic rd_rise;

    // Strobe delay for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_strb;
    end

    // Edge pulses and per-register read starts
    always_comb begin
        rd_rise = rd_strb & ~rd_q;
        rd_end  = ~rd_strb & rd_q;
        start_a = rd_rise && (addr == ADR_STAT_A);
        start_b = rd_rise && (addr == ADR_STAT_B);
    end

    // Read data latched at the strobe rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_rise) begin
            case (addr)
                ADR_STAT_A: rd_data <= stat_a;
                ADR_STAT_B: rd_data <= stat_b;
                ADR_MASK_A: rd_data <= mask_a;
                default:    rd_data <= mask_b;
            endcase
        end
    end

    // Mask registers, written only at their own addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a <= '0;
            mask_b <= '0;
        end else if (wr_en) begin
            if (addr == ADR_MASK_A) mask_a <= wr_data;
            if (addr == ADR_MASK_B) mask_b <= wr_data;
        end
    end

    // R10
    r10_mask_a_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_MASK_A) |=> $stable(mask_a));

    // R10
    r10_mask_b_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADR_MASK_B) |=> $stable(mask_b));
endmodule

// File: rtl/irq_gen.sv
// Module: interrupt request output.
// The request is high when any set status bit is enabled by its mask and no
// status read is open. Purely combinational from registered state.
module irq_gen
    import irq_stat_pkg::*;
(
    input  logic [REG_W-1:0] stat_a,
    input  logic [REG_W-1:0] stat_b,
    input  logic [REG_W-1:0] mask_a,
    input  logic [REG_W-1:0] mask_b,
    input  logic             busy_a,
    input  logic             busy_b,
    output logic             irq
);
    logic pend;

    // Masked pending reduction, suppressed during any status read
    always_comb begin
        pend = |((stat_a & mask_a) | (stat_b & mask_b));
        irq  = pend && !(busy_a || busy_b);
    end
endmodule

// File: rtl/irq_stat_ctrl.sv
// Module: top of the read-to-clear interrupt status controller.
// Wires the register port, two status captures and the request output.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module irq_stat_ctrl
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_strb,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [5:0]        ev_frame,
    input  logic [4:0]        ev_misc,
    input  logic              ev_fatal,
    output logic              irq
);
    logic [REG_W-1:0] stat_a, stat_b, mask_a, mask_b;
    logic [REG_W-1:0] ev_a, ev_b;
    logic             start_a, start_b, rd_end, busy_a, busy_b;

    // Place the event pulses at their register bit positions
    always_comb begin
        ev_a = {2'b00, ev_frame};
        ev_b = {ev_fatal, 2'b00, ev_misc};
    end

    reg_port u_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_strb(rd_strb),
        .wr_en(wr_en), .wr_data(wr_data), .stat_a(stat_a), .stat_b(stat_b),
        .rd_data(rd_data), .mask_a(mask_a), .mask_b(mask_b),
        .start_a(start_a), .start_b(start_b), .rd_end(rd_end)
    );

    stat_capture #(.W(REG_W), .VALID(A_VALID), .STICKY(A_STICKY)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev(ev_a),
        .rd_start(start_a), .rd_end(rd_end), .stat_q(stat_a), .busy_q(busy_a)
    );

    stat_capture #(.W(REG_W), .VALID(B_VALID), .STICKY(B_STICKY)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev(ev_b),
        .rd_start(start_b), .rd_end(rd_end), .stat_q(stat_b), .busy_q(busy_b)
    );

    irq_gen u_irq (
        .stat_a(stat_a), .stat_b(stat_b), .mask_a(mask_a), .mask_b(mask_b),
        .busy_a(busy_a), .busy_b(busy_b), .irq(irq)
    );

    // R4
    r4_quiet_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_a || busy_b) |-> !irq);

    // R5
    r5_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_a || busy_b) && |((stat_a & mask_a) | (stat_b & mask_b))) |-> irq);

    // R7
    r7_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_b |=> (rd_data[6:5] == 2'b00));
endmodule

// File: tb/irq_stat_ctrl_tb.sv
module irq_stat_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, soft_rst = 1'b0;
    logic [1:0] addr = '0;
    logic       rd_strb = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] ev_frame = '0;
    logic [4:0] ev_misc = '0;
    logic       ev_fatal = 1'b0;
    logic       irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    irq_stat_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr),
        .rd_strb(rd_strb), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_frame(ev_frame), .ev_misc(ev_misc), .ev_fatal(ev_fatal), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] fa, input logic [4:0] fb, input logic ff);
        @(negedge clk); ev_frame = fa; ev_misc = fb; ev_fatal = ff;
        @(negedge clk); ev_frame = '0; ev_misc = '0; ev_fatal = 1'b0;
    endtask

    // Two-cycle read; mid_a pulses ev_frame during the open read
    task automatic rd(input logic [1:0] a, input logic [5:0] mid_a,
                      output logic [7:0] data, output logic irq_mid, output logic irq_after);
        @(negedge clk); addr = a; rd_strb = 1'b1;
        @(negedge clk); data = rd_data; ev_frame = mid_a;
        @(negedge clk); ev_frame = '0; irq_mid = irq; rd_strb = 1'b0;
        @(negedge clk); irq_after = irq;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic im, ia;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 hardware reset state
        check("R9 reset irq", {7'd0, irq}, 8'h00);
        check("R9 reset rd_data", rd_data, 8'h00);
        rd(2'd2, 6'd0, d, im, ia); check("R9 reset mask A", d, 8'h00);
        rd(2'd3, 6'd0, d, im, ia); check("R9 reset mask B", d, 8'h00);

        // R6 R1 R3: each frame event alone, masks zero
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i), 5'd0, 1'b0);
            check("R3 masked irq", {7'd0, irq}, 8'h00);
            rd(2'd0, 6'd0, d, im, ia); check("R6 bit map A", d, 8'(1 << i));
            rd(2'd0, 6'd0, d, im, ia); check("R1 cleared A", d, 8'h00);
        end
        // R7 each misc event, then all at once
        for (int i = 0; i < 5; i++) begin
            pulse(6'd0, 5'(1 << i), 1'b0);
            rd(2'd1, 6'd0, d, im, ia); check("R7 bit map B", d, 8'(1 << i));
        end
        pulse(6'd0, 5'h1F, 1'b0);
        rd(2'd1, 6'd0, d, im, ia); check("R7 bits 5,6 zero", d, 8'h1F);
        rd(2'd1, 6'd0, d, im, ia); check("R1 cleared B", d, 8'h00);

        // R3 R10 mask sweep on register A
        for (int m = 0; m < 6; m++) begin
            wr(2'd2, 8'(1 << m));
            rd(2'd2, 6'd0, d, im, ia); check("R10 mask A readback", d, 8'(1 << m));
            for (int j = 0; j < 6; j++) begin
                pulse(6'(1 << j), 5'd0, 1'b0);
                check("R3 irq gate A", {7'd0, irq}, {7'd0, m == j});
                rd(2'd0, 6'd0, d, im, ia);
            end
        end
        wr(2'd2, 8'h00);
        // R3 R10 mask sweep on register B
        for (int m = 0; m < 5; m++) begin
            wr(2'd3, 8'(1 << m));
            rd(2'd3, 6'd0, d, im, ia); check("R10 mask B readback", d, 8'(1 << m));
            for (int j = 0; j < 5; j++) begin
                pulse(6'd0, 5'(1 << j), 1'b0);
                check("R3 irq gate B", {7'd0, irq}, {7'd0, m == j});
                rd(2'd1, 6'd0, d, im, ia);
            end
        end
        wr(2'd3, 8'h00);

        // R2 R4 R5 event during an open read
        wr(2'd2, 8'h3F);
        pulse(6'h01, 5'd0, 1'b0);
        check("R3 irq pending", {7'd0, irq}, 8'h01);
        rd(2'd0, 6'h04, d, im, ia);
        check("R2 data excludes mid event", d, 8'h01);
        check("R4 irq low in read", {7'd0, im}, 8'h00);
        check("R5 irq back after read", {7'd0, ia}, 8'h01);
        rd(2'd0, 6'd0, d, im, ia);
        check("R2 mid event next read", d, 8'h04);
        check("R5 irq low nothing pending", {7'd0, ia}, 8'h00);
        // R2 event on the strobe-rise edge itself
        @(negedge clk); addr = 2'd0; rd_strb = 1'b1; ev_frame = 6'h08;
        @(negedge clk); ev_frame = '0; d = rd_data;
        check("R2 rise-edge event excluded", d, 8'h00);
        check("R4 irq low at open", {7'd0, irq}, 8'h00);
        rd_strb = 1'b0;
        @(negedge clk);
        check("R5 irq after rise-edge event", {7'd0, irq}, 8'h01);
        rd(2'd0, 6'd0, d, im, ia); check("R2 rise-edge event kept", d, 8'h08);

        // R8 sticky fatal bit
        wr(2'd3, 8'h80);
        pulse(6'd0, 5'd0, 1'b1);
        check("R8 fatal irq", {7'd0, irq}, 8'h01);
        rd(2'd1, 6'd0, d, im, ia);
        check("R8 fatal read", d, 8'h80);
        check("R8 irq stays after read", {7'd0, ia}, 8'h01);
        rd(2'd1, 6'd0, d, im, ia); check("R8 fatal survives read", d, 8'h80);

        // R10 writes do not touch status
        pulse(6'h02, 5'd0, 1'b0);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h3F);
        rd(2'd0, 6'd0, d, im, ia); check("R10 status A unchanged", d, 8'h02);
        rd(2'd1, 6'd0, d, im, ia); check("R10 status B unchanged", d, 8'h80);

        // R9 soft reset, including a shadow captured in an open read
        pulse(6'h10, 5'h01, 1'b0);
        @(negedge clk); addr = 2'd0; rd_strb = 1'b1;
        @(negedge clk); ev_frame = 6'h20;
        @(negedge clk); ev_frame = '0; soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0; rd_strb = 1'b0;
        @(negedge clk);
        check("R9 irq after soft reset", {7'd0, irq}, 8'h00);
        rd(2'd0, 6'd0, d, im, ia); check("R9 status A and shadow cleared", d, 8'h00);
        rd(2'd1, 6'd0, d, im, ia); check("R9 status B and fatal cleared", d, 8'h00);
        rd(2'd2, 6'd0, d, im, ia); check("R9 mask A kept", d, 8'h3F);
        rd(2'd3, 6'd0, d, im, ia); check("R9 mask B kept", d, 8'h80);
        // R9 hardware reset clears masks
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(2'd2, 6'd0, d, im, ia); check("R9 hw reset mask A", d, 8'h00);
        rd(2'd3, 6'd0, d, im, ia); check("R9 hw reset mask B", d, 8'h00);

        finish_run();
    end
endmodule